// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous 128K x 8 static RAM. The host hands over one read or write at a time through a request/ready handshake. The controller then produces the memory's address, its two chip selects (one active low, one active high), an active-low output enable, an active-low write enable, and the byte data with a driver enable for the shared tri-state bus. Each read ends with a one-cycle response pulse that carries the captured byte.

Every timing rule of the memory is written in nanoseconds, together with the clock period, as a module parameter. Each one is rounded up to whole clock cycles. Separate per-phase counters enforce the read access window, the write strobe width (the longer of pulse width and data setup), a bus turnaround after reads and a minimum overall cycle time. No single fixed wait state is used.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, memSelN=1, memSel=0, memOeN=1, memWeN=1, memDoutEn=0 and reqReady=1.
- R2: A read selects the chip (memSelN=0, memSel=1) with memOeN=0 and memWeN=1 for ceil(accessNs/clkNs) cycles. It captures memDin at the end of that window and returns it on rspData with rspValid high for exactly one cycle.
- R3: A write holds memWeN low with the chip selected for max(ceil(pulseNs/clkNs), ceil(setupNs/clkNs)) cycles. Write data stays on memDout, unchanged, for that whole time.
- R4: memOeN is high whenever memWeN is low, and memDoutEn is high only while memWeN is low with the chip selected.
- R5: After a read, the data drivers stay off for at least ceil(hizNs/clkNs) cycles after memOeN rises.
- R6: reqReady goes low on the cycle after a request is accepted. It stays low for max(ceil(cycleNs/clkNs), length of the active phases) cycles, which is 6 cycles at the default parameters for reads and for writes.
- R7: memAddr does not change while the chip is selected.
- R8: A request raised while reqReady is low is ignored and causes no memory access.
- R9: A run of writes issued back to back, followed by reads of the same addresses (including 0x00000 and 0x1FFFF), returns the written bytes in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Controller accepts a request this cycle |
| rspValid | output | 1 | One-cycle pulse, rspData holds a read byte |
| rspData | output | 8 | Captured read byte |
| memAddr | output | 17 | Address to the memory |
| memSelN | output | 1 | Active-low chip select |
| memSel | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDout | output | 8 | Byte driven toward the memory |
| memDoutEn | output | 1 | Driver enable for the tri-state bus |
| memDin | input | 8 | Byte read from the bus |

## Verification
The assertions assume that memDin is meaningful only near the end of the access window. They also assume the host presents reqAddr, reqWrite and reqWdata in the same cycle as reqValid. The bench meets both assumptions. It drives requests only on falling edges, and its memory model returns a poison byte until the output enable has been low for the full access time. The model keeps driving for the high-impedance delay after each read, so a driver that turns on early is seen as contention. Stray requests are raised only while reqReady is low, so their inputs never reach an accepted cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_TURN     = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_RECOVER  = 3'd4
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // load request registers
    logic chipOn;   // both selects active
    logic readOn;   // output enable active
    logic writeOn;  // write strobe and data drivers active
    logic capture;  // sample the bus into the read register
  } strobe_t;

  function automatic int ceilCycles(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ACC_CYC  = 6,
  parameter int WR_CYC   = 4,
  parameter int TURN_CYC = 2,
  parameter int CYC_CYC  = 6,
  parameter int CNT_W    = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam logic [CNT_W-1:0] ACC_LOAD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);
  localparam logic [CNT_W-1:0] CYC_LOAD  = CNT_W'(CYC_CYC - 1);
  localparam bit               HAS_TURN  = (TURN_CYC > 0);

  ctrl_state_e state, stateNext;
  logic [CNT_W-1:0] phaseCnt, phaseNext;
  logic [CNT_W-1:0] cycLeft;
  logic needTurn;
  logic accept, phaseDone, endOfOp;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign phaseDone = (phaseCnt == '0);
  assign endOfOp   = ((state == ST_RD_ACC) || (state == ST_WR_PULSE)) && phaseDone;

  always_comb begin
    stateNext = state;
    phaseNext = phaseCnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqWrite) begin
            stateNext = ST_RD_ACC;
            phaseNext = ACC_LOAD;
          end else if (needTurn && HAS_TURN) begin
            stateNext = ST_TURN;
            phaseNext = TURN_LOAD;
          end else begin
            stateNext = ST_WR_PULSE;
            phaseNext = WR_LOAD;
          end
        end
      end
      ST_TURN: begin
        if (phaseDone) begin
          stateNext = ST_WR_PULSE;
          phaseNext = WR_LOAD;
        end else begin
          phaseNext = phaseCnt - 1'b1;
        end
      end
      ST_RD_ACC, ST_WR_PULSE: begin
        if (phaseDone) stateNext = (cycLeft == '0) ? ST_IDLE : ST_RECOVER;
        else           phaseNext = phaseCnt - 1'b1;
      end
      ST_RECOVER: begin
        if (cycLeft == '0) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      cycLeft  <= '0;
      needTurn <= 1'b0;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseNext;
      if (accept)                                 cycLeft <= CYC_LOAD;
      else if (state != ST_IDLE && cycLeft != '0) cycLeft <= cycLeft - 1'b1;
      if (state == ST_RD_ACC && phaseDone)        needTurn <= 1'b1;
      else if (state == ST_WR_PULSE)              needTurn <= 1'b0;
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign strb.accept  = accept;
  assign strb.chipOn  = (state == ST_RD_ACC) || (state == ST_WR_PULSE);
  assign strb.readOn  = (state == ST_RD_ACC);
  assign strb.writeOn = (state == ST_WR_PULSE);
  assign strb.capture = (state == ST_RD_ACC) && phaseDone;

  // checker counter: busy cycles since the last accepted request
  logic [CNT_W:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                busyCnt <= '0;
    else if (accept)                          busyCnt <= '0;
    else if (!reqReady && busyCnt != '1)      busyCnt <= busyCnt + 1'b1;
  end

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_cycle_min_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> (busyCnt >= (CNT_W+1)'(CYC_CYC)));

  assert_op_end_returns_R6: assert property (@(posedge clk) disable iff (!rstN)
    endOfOp |=> !strb.chipOn);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] memDin,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic [AW-1:0] memAddr,
  output logic          memSelN,
  output logic          memSel,
  output logic          memOeN,
  output logic          memWeN,
  output logic [DW-1:0] memDout,
  output logic          memDoutEn
);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] wdataQ, rdataQ;
  logic          rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.accept) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= strb.capture;
      if (strb.capture) rdataQ <= memDin;
    end
  end

  assign memAddr   = addrQ;
  assign memSelN   = ~strb.chipOn;
  assign memSel    = strb.chipOn;
  assign memOeN    = ~strb.readOn;
  assign memWeN    = ~strb.writeOn;
  assign memDout   = wdataQ;
  assign memDoutEn = strb.writeOn;
  assign rspValid  = rspQ;
  assign rspData   = rdataQ;

  assert_rsp_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_wdata_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEn && $past(memDoutEn)) |-> $stable(memDout));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int PULSE_NS = 40,
  parameter int SETUP_NS = 25,
  parameter int ACC_NS  = 55,
  parameter int HIZ_NS  = 20,
  parameter int CYCLE_NS = 55
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic          reqReady,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic [AW-1:0] memAddr,
  output logic          memSelN,
  output logic          memSel,
  output logic          memOeN,
  output logic          memWeN,
  output logic [DW-1:0] memDout,
  output logic          memDoutEn,
  input  logic [DW-1:0] memDin
);

  localparam int ACC_CYC  = maxOf(ceilCycles(ACC_NS, CLK_NS), 1);
  localparam int WR_CYC   = maxOf(maxOf(ceilCycles(PULSE_NS, CLK_NS),
                                        ceilCycles(SETUP_NS, CLK_NS)), 1);
  localparam int TURN_CYC = ceilCycles(HIZ_NS, CLK_NS);
  localparam int CYC_CYC  = maxOf(ceilCycles(CYCLE_NS, CLK_NS), 1);
  localparam int MAX_CYC  = maxOf(maxOf(ACC_CYC, WR_CYC), maxOf(TURN_CYC, CYC_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 2);

  strobe_t strb;

  sram_ctrl_fsm #(
    .ACC_CYC (ACC_CYC),
    .WR_CYC  (WR_CYC),
    .TURN_CYC(TURN_CYC),
    .CYC_CYC (CYC_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sram_ctrl_dp #(
    .AW(AW),
    .DW(DW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .rspValid (rspValid),
    .rspData  (rspData),
    .memAddr  (memAddr),
    .memSelN  (memSelN),
    .memSel   (memSel),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memDout  (memDout),
    .memDoutEn(memDoutEn)
  );

  // checker counter: cycles with output enable high
  logic [CNT_W:0] oeHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    oeHighCnt <= '1;
    else if (!memOeN)             oeHighCnt <= '0;
    else if (oeHighCnt != '1)     oeHighCnt <= oeHighCnt + 1'b1;
  end

  assert_idle_inactive_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memSelN && !memSel && memOeN && memWeN && !memDoutEn));

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memSelN && memSel && memWeN));

  assert_drive_in_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> (!memWeN && !memSelN && memSel));

  assert_no_oe_in_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> (oeHighCnt > (CNT_W+1)'(TURN_CYC)));

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memSelN && $past(!memSelN)) |-> $stable(memAddr));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int CLK_NS   = 10;
  localparam int ACC_CYC  = 6;   // ceil(55/10)
  localparam int WP_CYC   = 4;   // ceil(40/10)
  localparam int DS_CYC   = 3;   // ceil(25/10)
  localparam int HIZ_CYC  = 2;   // ceil(20/10)
  localparam int BUSY_CYC = 6;   // ceil(55/10), longest phase set is also 6

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid, memSelN, memSel, memOeN, memWeN, memDoutEn;
  logic [7:0]  rspData, memDout;
  logic [16:0] memAddr;
  logic [7:0]  memDin = 8'hEE;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] refMem[int];
  logic [7:0] modelMem[int];
  int wrEvents = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memSelN(memSelN), .memSel(memSel), .memOeN(memOeN), .memWeN(memWeN),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  int  rdCnt = 0, wrCnt = 0, setupCnt = 0, hizLeft = 0;
  bit  rdPrev = 0, wrPrev = 0;
  logic [7:0]  lastData;
  logic [16:0] lastAddr;
  always @(negedge clk) begin
    automatic bit sel   = !memSelN && memSel;
    automatic bit rdAct = sel && !memOeN && memWeN;
    automatic bit wrAct = sel && !memWeN;
    if (rdAct) begin
      rdCnt++;
      memDin <= (rdCnt >= ACC_CYC && modelMem.exists(int'(memAddr))) ? modelMem[int'(memAddr)] : 8'hEE;
    end else begin
      rdCnt = 0;
      memDin <= 8'hEE;
    end
    if (rdPrev && !rdAct)        hizLeft = HIZ_CYC;
    else if (!rdAct && hizLeft > 0) hizLeft--;
    rdPrev = rdAct;
    if (memDoutEn && (rdAct || hizLeft > 0))
      check(0, "R5 bus contention", hizLeft, 0);
    if (wrAct && !memOeN) check(0, "R4 oe low during write", 0, 1);
    if (wrAct) begin
      if (memDoutEn && wrCnt > 0 && memDout == lastData) setupCnt++;
      else if (memDoutEn)                                setupCnt = 1;
      else                                               setupCnt = 0;
      wrCnt++;
      lastData = memDout;
      lastAddr = memAddr;
    end else if (wrPrev) begin
      check(wrCnt >= WP_CYC, "R3 write pulse width", wrCnt, WP_CYC);
      check(setupCnt >= DS_CYC, "R3 data setup", setupCnt, DS_CYC);
      modelMem[int'(lastAddr)] = lastData;
      wrEvents++;
      wrCnt = 0;
    end
    wrPrev = wrAct;
  end

  // ---------------- response monitor (scoreboard) ----------------
  bit rspPrev = 0;
  always @(negedge clk) begin
    if (rspValid) begin
      if (rspPrev) check(0, "R2 rspValid longer than one cycle", 1, 0);
      if (expQ.size() == 0) check(0, "R2 unexpected response", rspData, 0);
      else begin
        automatic logic [7:0] e = expQ.pop_front();
        check(rspData == e, "R2/R9 read data", rspData, e);
      end
    end
    rspPrev = rspValid;
  end

  // ---------------- driver ----------------
  task automatic doOp(input bit wr, input logic [16:0] a, input logic [7:0] d,
                      output int busy);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    if (wr) refMem[int'(a)] = d;
    else    expQ.push_back(refMem.exists(int'(a)) ? refMem[int'(a)] : 8'hEE);
    @(negedge clk);
    reqValid = 1'b0;
    busy = 0;
    while (!reqReady) begin
      busy++;
      @(negedge clk);
    end
  endtask

  initial begin
    int busy;
    int wrBefore;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(memSelN === 1'b1, "R1 memSelN in reset", memSelN, 1);
    check(memDoutEn === 1'b0, "R1 drivers off in reset", memDoutEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(memSelN && !memSel, "R1 selects idle", {memSelN, memSel}, 2);
    check(memOeN && memWeN, "R1 enables idle", {memOeN, memWeN}, 3);
    check(reqReady === 1'b1, "R1 ready idle", reqReady, 1);

    // R9 back-to-back writes including boundary addresses
    doOp(1, 17'h00000, 8'h11, busy);
    check(busy == BUSY_CYC, "R6 write busy", busy, BUSY_CYC);
    doOp(1, 17'h1FFFF, 8'hA5, busy);
    doOp(1, 17'h00155, 8'h5A, busy);
    doOp(1, 17'h0AAAA, 8'hFF, busy);
    doOp(1, 17'h10000, 8'h00, busy);
    doOp(0, 17'h00000, 8'h00, busy);
    check(busy == BUSY_CYC, "R6 read busy", busy, BUSY_CYC);
    doOp(0, 17'h1FFFF, 8'h00, busy);
    doOp(0, 17'h00155, 8'h00, busy);
    doOp(0, 17'h0AAAA, 8'h00, busy);
    doOp(0, 17'h10000, 8'h00, busy);

    // R5 write right after a read, then read it back
    doOp(0, 17'h00155, 8'h00, busy);
    doOp(1, 17'h00155, 8'hC3, busy);
    check(busy == BUSY_CYC, "R6 write after read busy", busy, BUSY_CYC);
    doOp(0, 17'h00155, 8'h00, busy);

    // R8 stray request while busy
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 17'h0AAAA;
    expQ.push_back(refMem[int'(17'h0AAAA)]);
    @(negedge clk);
    wrBefore = wrEvents;
    reqWrite = 1'b1; reqAddr = 17'h1FFFF; reqWdata = 8'h77;   // ignored, busy
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    repeat (2) @(negedge clk);
    check(wrEvents == wrBefore, "R8 stray write ignored", wrEvents, wrBefore);
    doOp(0, 17'h1FFFF, 8'h00, busy);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all reads answered", expQ.size(), 0);
    check(memSelN && !memSel && memOeN && memWeN && !memDoutEn,
          "R1 idle after traffic", 0, 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule